// File: doc/BRIEF.md
# Configuration item read port

The block holds a fixed set of read-only configuration items and hands them out one byte stream at a time over a simple register bus. Items sit in two banks of equal size: a shared bank and an architecture-local bank. Software writes a 16-bit key to the selector port. The key picks a bank and an item, and rewinds the item's byte cursor. Each read of the data port then returns the next 1 to 8 bytes of the item. The cursor moves forward by the number of bytes actually delivered.

Item contents are fixed when the block is elaborated. An entry table gives each item a 32-bit length and a base offset into one shared byte store. A length of zero means the item has no data. A multi-byte read places the first byte in the most significant position of its field. When the item runs out partway through an access, the low bytes that were not delivered read as zero. A key whose index is out of range selects nothing, and every read of it returns zero.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, `bus_rdata` is 0, the cursor is 0 and key 0 (shared bank, index 0) is selected. A 4-byte read then returns the signature item, the bytes of parameter `SIGNATURE` taken from most to least significant (default 0x43464721).
- R2: A selector write loads the key and rewinds the cursor to 0. A selector write is `bus_wr`=1, `bus_rd`=0, `bus_addr`=0 and `bus_size`=1 (two bytes). The key is taken big-endian: byte lane 0 (`bus_wdata[7:0]`) is the high key byte and lane 1 is the low key byte.
- R3: A write to the selector port with any other size changes neither the key nor the cursor.
- R4: Key bit 15 selects the architecture-local bank, and bits 14:0 index an item within the bank. If the index is equal to or greater than `NUM_ENTRIES`, the key is invalid: every data read returns 0 and the cursor does not move.
- R5: A data read is `bus_rd`=1 with `bus_addr`=1. It asks for N = `bus_size`+1 bytes. The result is right-aligned in `bus_rdata[8N-1:0]`: the byte at the cursor goes in bits 8N-1:8N-8, the next byte just below it, and so on. Bits at and above 8N are zero.
- R6: A data read advances the cursor by the number of bytes it delivered, so successive reads continue through the item.
- R7: If the item ends after k < N bytes, those k bytes are placed as in R5, the missing low bytes are zero, and the cursor stops at the item length.
- R8: A read with the cursor at the item length, or of an item of length 0, returns 0 and leaves the cursor unchanged.
- R9: Writes to the data port have no effect on the cursor, the key or `bus_rdata`.
- R10: The identification item (shared bank, index 1) is 4 bytes long. Its first byte is 0x01, OR-ed with 0x02 when `HAS_DMA` is 1; its other bytes are 0.
- R11: Every other item in bank b at index i has length (3i+5b) mod (`MAX_ITEM_LEN`+1). Its byte at offset o is 0x5A XOR {b, i[2:0], o[3:0]}.
- R12: `bus_rdata` changes only on the clock edge that samples `bus_rd`=1, and holds its value on every other cycle. A read of the selector port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | Port select: 0 = selector, 1 = data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; takes precedence over `bus_wr` |
| bus_size | input | $clog2(BUS_BYTES) | Access size in bytes, minus one |
| bus_wdata | input | 8*BUS_BYTES | Write data |
| bus_rdata | output | 8*BUS_BYTES | Registered read data |

## Verification
A selector write takes effect at the clock edge that samples it, so a data read issued in the following cycle already uses the new key and a cursor of zero. Read data is registered once. The value for a read strobe sampled at edge n is therefore visible from just after edge n. The bench drives each operation on a falling edge and samples `bus_rdata` on the next falling edge, half a period after the capturing edge. One directed check leaves an idle cycle after a read and confirms the value holds, and the reset checks sample during reset and after its release.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

   localparam logic PORT_SEL  = 1'b0;
   localparam logic PORT_DATA = 1'b1;

   localparam logic [7:0] VER_BASE = 8'h01;
   localparam logic [7:0] VER_DMA  = 8'h02;
   localparam logic [7:0] FILL_XOR = 8'h5A;

   localparam int KEY_W      = 16;
   localparam int KEY_BANK_B = 15;

   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // default length of item (bank b, index i)
   function automatic logic [31:0] dflt_len(input bit b, input int i, input int max_len);
      if (!b && (i == 0 || i == 1)) return 32'd4;
      return 32'((3 * i + 5 * int'(b)) % (max_len + 1));
   endfunction

   // default byte at offset o of item (bank b, index i)
   function automatic logic [7:0] dflt_byte(input bit b, input int i, input int o,
                                            input logic [31:0] sig, input logic [7:0] ver);
      logic [2:0] ib;
      logic [3:0] ob;
      ib = 3'(i);
      ob = 4'(o);
      if (!b && i == 0) begin
         case (o)
            0:       return sig[31:24];
            1:       return sig[23:16];
            2:       return sig[15:8];
            default: return sig[7:0];
         endcase
      end
      if (!b && i == 1) return (o == 0) ? ver : 8'h00;
      return FILL_XOR ^ {b, ib, ob};
   endfunction

endpackage

// File: rtl/cfg_key_decode.sv
module cfg_key_decode import cfg_item_pkg::*; #(
   parameter int NUM_ENTRIES = 8,
   parameter int IDX_W       = idx_width(NUM_ENTRIES)
) (
   input  logic [KEY_W-1:0] key_i,
   output logic             ok_o,
   output logic             bank_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [KEY_BANK_B-1:0] raw_idx;

   assign raw_idx = key_i[KEY_BANK_B-1:0];
   assign bank_o  = key_i[KEY_BANK_B];
   assign ok_o    = int'(raw_idx) < NUM_ENTRIES;
   assign idx_o   = raw_idx[IDX_W-1:0];
endmodule

// File: rtl/cfg_item_table.sv
module cfg_item_table import cfg_item_pkg::*; #(
   parameter int          NUM_ENTRIES  = 8,
   parameter int          MAX_ITEM_LEN = 8,
   parameter int          BUS_BYTES    = 8,
   parameter logic [31:0] SIGNATURE    = 32'h4346_4721,
   parameter bit          HAS_DMA      = 1'b1,
   parameter int          IDX_W        = idx_width(NUM_ENTRIES)
) (
   input  logic                      bank_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [31:0]               cursor_i,
   output logic [31:0]               len_o,
   output logic [BUS_BYTES-1:0][7:0] window_o
);
   localparam int SLOTS  = 2 * NUM_ENTRIES;
   localparam int DEPTH  = SLOTS * MAX_ITEM_LEN;
   localparam int SLOT_W = idx_width(SLOTS);
   localparam int ROM_AW = idx_width(DEPTH);

   logic [7:0]        version;
   logic [31:0]       lens [SLOTS];
   logic [7:0]        rom  [DEPTH];
   logic [SLOT_W-1:0] slot;
   logic              slot_ok;

   if (HAS_DMA) begin : g_ver_dma
      assign version = VER_BASE | VER_DMA;
   end else begin : g_ver_plain
      assign version = VER_BASE;
   end

   // entry table and byte store, base of slot s is s*MAX_ITEM_LEN
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam bit B = (s >= NUM_ENTRIES);
      localparam int I = B ? s - NUM_ENTRIES : s;
      localparam logic [31:0] LEN = dflt_len(B, I, MAX_ITEM_LEN);
      assign lens[s] = LEN;
      for (genvar o = 0; o < MAX_ITEM_LEN; o++) begin : g_byte
         assign rom[s * MAX_ITEM_LEN + o] =
            (32'(o) < LEN) ? dflt_byte(B, I, o, SIGNATURE, version) : 8'h00;
      end
   end

   assign slot_ok = int'(idx_i) < NUM_ENTRIES;
   assign slot    = SLOT_W'((bank_i ? NUM_ENTRIES : 0) + int'(idx_i));
   assign len_o   = slot_ok ? lens[slot] : 32'd0;

   // byte window starting at the cursor
   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      logic [31:0]       off;
      logic [ROM_AW-1:0] addr;
      assign off  = cursor_i + 32'(k);
      assign addr = ROM_AW'(int'(slot) * MAX_ITEM_LEN + int'(off[ROM_AW-1:0]));
      assign window_o[k] = (slot_ok && off < 32'(MAX_ITEM_LEN)) ? rom[addr] : 8'h00;
   end
endmodule

// File: rtl/cfg_byte_packer.sv
module cfg_byte_packer #(
   parameter int BUS_BYTES = 8,
   parameter int SIZE_W    = $clog2(BUS_BYTES)
) (
   input  logic [SIZE_W-1:0]          size_i,
   input  logic [31:0]                avail_i,
   input  logic [BUS_BYTES-1:0][7:0]  window_i,
   output logic [8*BUS_BYTES-1:0]     value_o,
   output logic [SIZE_W:0]            adv_o
);
   localparam logic [SIZE_W:0] ONE = 1;

   int n;

   always_comb begin
      n       = int'(size_i) + 1;
      value_o = '0;
      adv_o   = '0;
      for (int k = 0; k < BUS_BYTES; k++) begin
         if (k < n && 32'(k) < avail_i) begin
            value_o[8 * (n - 1 - k) +: 8] = window_i[k];
            adv_o = adv_o + ONE;
         end
      end
   end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port import cfg_item_pkg::*; #(
   parameter int          NUM_ENTRIES  = 8,
   parameter int          MAX_ITEM_LEN = 8,
   parameter int          BUS_BYTES    = 8,
   parameter logic [31:0] SIGNATURE    = 32'h4346_4721,
   parameter bit          HAS_DMA      = 1'b1,
   localparam int         SIZE_W       = $clog2(BUS_BYTES),
   localparam int         DW           = 8 * BUS_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [SIZE_W-1:0] bus_size,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata
);
   localparam int IDX_W = idx_width(NUM_ENTRIES);

   if (BUS_BYTES < 2 || BUS_BYTES > 8 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("BUS_BYTES must be 2, 4 or 8");
   end
   if (MAX_ITEM_LEN < 4) begin : g_bad_len
      $error("MAX_ITEM_LEN must hold the 4-byte fixed items");
   end
   if (NUM_ENTRIES < 2 || NUM_ENTRIES > (1 << KEY_BANK_B)) begin : g_bad_cnt
      $error("NUM_ENTRIES out of range");
   end

   logic [KEY_W-1:0]         key_q;
   logic [31:0]              cursor_q;
   logic [DW-1:0]            rdata_q;
   logic                     key_ok, key_bank;
   logic [IDX_W-1:0]         key_idx;
   logic [31:0]              item_len, avail;
   logic [BUS_BYTES-1:0][7:0] window;
   logic [DW-1:0]            packed_val;
   logic [SIZE_W:0]          adv;
   logic                     sel_wr, data_rd, data_wr, bad_sel_wr;

   cfg_key_decode #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dec (
      .key_i (key_q),
      .ok_o  (key_ok),
      .bank_o(key_bank),
      .idx_o (key_idx)
   );

   cfg_item_table #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .MAX_ITEM_LEN(MAX_ITEM_LEN),
      .BUS_BYTES   (BUS_BYTES),
      .SIGNATURE   (SIGNATURE),
      .HAS_DMA     (HAS_DMA),
      .IDX_W       (IDX_W)
   ) u_tab (
      .bank_i  (key_bank),
      .idx_i   (key_idx),
      .cursor_i(cursor_q),
      .len_o   (item_len),
      .window_o(window)
   );

   assign avail = (key_ok && cursor_q < item_len) ? item_len - cursor_q : 32'd0;

   cfg_byte_packer #(.BUS_BYTES(BUS_BYTES), .SIZE_W(SIZE_W)) u_pack (
      .size_i  (bus_size),
      .avail_i (avail),
      .window_i(window),
      .value_o (packed_val),
      .adv_o   (adv)
   );

   assign sel_wr     = bus_wr && !bus_rd && bus_addr == PORT_SEL && bus_size == SIZE_W'(1);
   assign bad_sel_wr = bus_wr && !bus_rd && bus_addr == PORT_SEL && bus_size != SIZE_W'(1);
   assign data_wr    = bus_wr && !bus_rd && bus_addr == PORT_DATA;
   assign data_rd    = bus_rd && bus_addr == PORT_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q    <= '0;
         cursor_q <= '0;
         rdata_q  <= '0;
      end else begin
         if (sel_wr) begin
            key_q    <= {bus_wdata[7:0], bus_wdata[15:8]};
            cursor_q <= '0;
         end
         if (bus_rd) rdata_q <= data_rd ? packed_val : '0;
         if (data_rd) cursor_q <= cursor_q + 32'(adv);
      end
   end

   assign bus_rdata = rdata_q;

   p_sel_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> cursor_q == 32'd0);

   p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bad_sel_wr |=> $stable(key_q) && $stable(cursor_q));

   p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !key_ok) |=> bus_rdata == '0 && $stable(cursor_q));

   p_adv_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |-> int'(adv) <= int'(bus_size) + 1);

   p_cursor_in_item_r7: assert property (@(posedge clk) disable iff (!rst_n)
      key_ok |-> cursor_q <= item_len);

   p_data_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> $stable(cursor_q) && $stable(key_q) && $stable(bus_rdata));

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/cfg_item_port_bench.sv
`timescale 1ns/1ps
module cfg_item_port_bench;
   localparam logic [1:0] OP_SEL = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic        addr;
      logic [2:0]  size;
      logic [63:0] wdata;
      logic [63:0] expv;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VECS [NV] = '{
      '{OP_RD,  1'b1, 3'd3, 64'h0,    64'h0000_0000_4346_4721, 8'd1},  // R1 signature
      '{OP_RD,  1'b1, 3'd1, 64'h0,    64'h0,                   8'd8},  // R8 at end
      '{OP_SEL, 1'b0, 3'd1, 64'h0100, 64'h0,                   8'd2},  // R2 key 0x0001
      '{OP_RD,  1'b1, 3'd7, 64'h0,    64'h0300_0000_0000_0000, 8'd10}, // R10 id item
      '{OP_SEL, 1'b0, 3'd1, 64'h0180, 64'h0,                   8'd2},  // R2 key 0x8001
      '{OP_RD,  1'b1, 3'd0, 64'h0,    64'h0000_0000_0000_00CA, 8'd5},  // R5
      '{OP_RD,  1'b1, 3'd1, 64'h0,    64'h0000_0000_0000_CBC8, 8'd6},  // R6
      '{OP_WR,  1'b1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,    8'd9},  // R9 data write
      '{OP_RD,  1'b1, 3'd3, 64'h0,    64'h0000_0000_C9CE_CFCC, 8'd9},  // R9 cursor kept
      '{OP_RD,  1'b1, 3'd1, 64'h0,    64'h0000_0000_0000_CD00, 8'd7},  // R7 padding
      '{OP_RD,  1'b1, 3'd0, 64'h0,    64'h0,                   8'd8},  // R8
      '{OP_SEL, 1'b0, 3'd1, 64'h0300, 64'h0,                   8'd2},  // key 0x0003 len 0
      '{OP_RD,  1'b1, 3'd3, 64'h0,    64'h0,                   8'd8},  // R8 empty item
      '{OP_SEL, 1'b0, 3'd1, 64'h0800, 64'h0,                   8'd2},  // key 0x0008 invalid
      '{OP_RD,  1'b1, 3'd7, 64'h0,    64'h0,                   8'd4},  // R4
      '{OP_SEL, 1'b0, 3'd1, 64'h0880, 64'h0,                   8'd2},  // key 0x8008 invalid
      '{OP_RD,  1'b1, 3'd7, 64'h0,    64'h0,                   8'd4},  // R4
      '{OP_SEL, 1'b0, 3'd1, 64'h0200, 64'h0,                   8'd2},  // key 0x0002 len 6
      '{OP_RD,  1'b1, 3'd0, 64'h0,    64'h0000_0000_0000_007A, 8'd11}, // R11
      '{OP_SEL, 1'b0, 3'd3, 64'h0400, 64'h0,                   8'd3},  // R3 wrong size
      '{OP_RD,  1'b1, 3'd0, 64'h0,    64'h0000_0000_0000_007B, 8'd3},  // R3 not rewound
      '{OP_SEL, 1'b0, 3'd1, 64'h0200, 64'h0,                   8'd2},  // R2 reselect
      '{OP_RD,  1'b1, 3'd2, 64'h0,    64'h0000_0000_007A_7B78, 8'd2},  // R2 rewound
      '{OP_SEL, 1'b0, 3'd1, 64'h0080, 64'h0,                   8'd2},  // key 0x8000 len 5
      '{OP_RD,  1'b1, 3'd7, 64'h0,    64'hDADB_D8D9_DE00_0000, 8'd7},  // R7
      '{OP_RD,  1'b0, 3'd1, 64'h0,    64'h0,                   8'd12}, // R12 selector read
      '{OP_SEL, 1'b0, 3'd1, 64'h0780, 64'h0,                   8'd2},  // key 0x8007 len 8
      '{OP_RD,  1'b1, 3'd7, 64'h0,    64'hAAAB_A8A9_AEAF_ACAD, 8'd4},  // R4 local bank
      '{OP_SEL, 1'b0, 3'd1, 64'h0280, 64'h0,                   8'd2},  // key 0x8002 len 2
      '{OP_RD,  1'b1, 3'd3, 64'h0,    64'h0000_0000_FAFB_0000, 8'd11}  // R11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_size = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfg_item_port u_cfg_item_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   task automatic check(input int req, input logic [63:0] got, input logic [63:0] expv);
      checks++;
      if (got !== expv) begin
         failures++;
         $display("FAIL R%0d got=%h expected=%h", req, got, expv);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic a, input logic [2:0] sz,
                        input logic [63:0] wd);
      @(negedge clk);
      bus_addr  = a;
      bus_size  = sz;
      bus_wdata = wd;
      bus_rd    = (op == OP_RD);
      bus_wr    = (op != OP_RD);
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1, bus_rdata, 64'h0);            // R1 during reset
      rst_n = 1'b1;
      for (int v = 0; v < NV; v++) begin
         apply(VECS[v].op, VECS[v].addr, VECS[v].size, VECS[v].wdata);
         if (VECS[v].op == OP_RD) check(int'(VECS[v].req), bus_rdata, VECS[v].expv);
      end
      // R12: idle cycles leave the last value in place
      repeat (2) @(negedge clk);
      check(12, bus_rdata, 64'h0000_0000_FAFB_0000);
      // R1: reset mid-run clears data and reselects key 0
      rst_n = 1'b0;
      @(negedge clk);
      check(1, bus_rdata, 64'h0);
      rst_n = 1'b1;
      apply(OP_RD, 1'b1, 3'd3, 64'h0);
      check(1, bus_rdata, 64'h0000_0000_4346_4721);
      // R5: a 2-byte read returns the first bytes right-aligned, upper bits zero
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      apply(OP_RD, 1'b1, 3'd1, 64'h0);
      check(5, bus_rdata, 64'h0000_0000_0000_4346);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end
endmodule